// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level page table held in memory, one word at a time. A caller, usually the translation cache that sits in front of it, starts a walk with a one-cycle request. The request carries the virtual address, a write flag, a user-mode flag and the physical base address of the page directory. The walker then reads the directory entry. If that entry is present, it reads the second-level entry. It finishes with a one-cycle completion pulse that carries either the translated address or a fault code.

Pages are 4 KB. The upper ten address bits select the directory slot, the next ten select the slot in the second-level table, and the low twelve bits are copied unchanged into the result. A directory entry that is not present means the whole second-level table is unallocated, so the walk stops at once. The walker handles one walk at a time and drops any request that arrives while it is busy.

Top module: `page_walker`

## Requirements
- R1: After reset, busy_o, done_o and mem_req_o are 0 and fault_o is 0.
- R2: The first read goes to base_i + 4 × va[31:22]. The base is captured with the request. mem_req_o stays high with mem_addr_o stable until a cycle with mem_rvalid_i high, and a response in that same cycle is accepted.
- R3: When the directory entry is present, the second read goes to entry[31:12] × 4096 + 4 × va[21:12].
- R4: A walk with no fault ends with done_o high for exactly one cycle, pa_o = second entry[31:12] concatenated with va[11:0], and fault_o = 0. Fault codes are 0 for none, 1 for not present and 2 for protection; 3 never appears.
- R5: A directory entry with bit 0 clear ends the walk with fault_o = 1 after exactly one memory read. pa_o is 0 on any fault.
- R6: A second-level entry with bit 0 clear gives fault_o = 1, whatever its other bits hold.
- R7: A write whose second-level entry has bit 1 (writable) clear gives fault_o = 2. A read of the same entry translates normally.
- R8: A user-mode access whose second-level entry has bit 2 (user) clear gives fault_o = 2. A supervisor access ignores bit 2.
- R9: A request seen while busy_o is high, including the completion cycle, is ignored. The walk in flight still returns its own result, and the walker is idle in the cycle after done_o.
- R10: Only present (bit 0) is checked in a directory entry; its bits 1 and 2 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | One-cycle walk request, taken only when idle |
| req_va_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | Access is a write |
| req_user_i | input | 1 | Access is from user mode |
| base_i | input | 32 | Physical base address of the page directory |
| mem_req_o | output | 1 | Word read outstanding |
| mem_addr_o | output | 32 | Byte address of the word read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pa_o | output | 32 | Physical address (0 on fault) |
| fault_o | output | 2 | 0 none, 1 not present, 2 protection |

## Verification
The assertions check the port protocol on every cycle. They cover the held, stable read request, a one-cycle completion, the return to idle, the rule that an idle walker stays idle without a request, and the legal fault codes. The bench's scenarios are needed to show the arithmetic and the decisions. Those include the two read addresses, the translated address, the single read on a null directory entry, the order in which absence and permission faults win, and requests dropped while busy. The scenarios run under read latencies of zero and several cycles and at the highest table indices.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DIR, ST_LEAF, ST_DONE} walk_st_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_ABSENT = 2'd1, FLT_PERM = 2'd2} flt_e;
  localparam int unsigned ENT_P = 0;
  localparam int unsigned ENT_W = 1;
  localparam int unsigned ENT_U = 2;
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned ENT_B = 2
) (
  input  logic [VA_W-1:0]        base_i,
  input  logic [VA_W-1:0]        va_i,
  input  logic [VA_W-OFF_W-1:0]  frame_i,
  input  logic                   leaf_i,
  output logic [VA_W-1:0]        addr_o
);
  localparam int unsigned FRM_W = VA_W - OFF_W;

  logic [IDX_W-1:0] dir_idx, tbl_idx;
  logic [VA_W-1:0]  dir_addr, leaf_addr;

  assign dir_idx = va_i[VA_W-1 -: IDX_W];
  assign tbl_idx = va_i[OFF_W +: IDX_W];

  assign dir_addr  = base_i + VA_W'({dir_idx, {ENT_B{1'b0}}});
  assign leaf_addr = {frame_i[FRM_W-1:0], {(OFF_W-IDX_W-ENT_B){1'b0}}, tbl_idx, {ENT_B{1'b0}}};
  assign addr_o    = leaf_i ? leaf_addr : dir_addr;
endmodule

// File: rtl/pw_perm_chk.sv
module pw_perm_chk
  import pw_pkg::*;
#(
  parameter int unsigned ENT_W_BITS = 32
) (
  input  logic [ENT_W_BITS-1:0] entry_i,
  input  logic                  leaf_i,
  input  logic                  write_i,
  input  logic                  user_i,
  output flt_e                  flt_o
);
  always_comb begin
    flt_o = FLT_NONE;
    if (!entry_i[ENT_P])
      flt_o = FLT_ABSENT;
    else if (leaf_i && ((write_i && !entry_i[ENT_W]) || (user_i && !entry_i[ENT_U])))
      flt_o = FLT_PERM;
  end
endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_valid_i,
  input  logic     rvalid_i,
  input  flt_e     flt_i,
  output walk_st_e st_o,
  output logic     take_req_o,
  output logic     take_frame_o,
  output logic     finish_o
);
  walk_st_e st_q, st_d;

  always_comb begin
    st_d         = st_q;
    take_req_o   = 1'b0;
    take_frame_o = 1'b0;
    finish_o     = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        take_req_o = 1'b1;
        st_d       = ST_DIR;
      end
      ST_DIR: if (rvalid_i) begin
        if (flt_i != FLT_NONE) begin
          finish_o = 1'b1;
          st_d     = ST_DONE;
        end else begin
          take_frame_o = 1'b1;
          st_d         = ST_LEAF;
        end
      end
      ST_LEAF: if (rvalid_i) begin
        finish_o = 1'b1;
        st_d     = ST_DONE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;

  assign st_o = st_q;
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [VA_W-1:0] req_va_i,
  input  logic            req_write_i,
  input  logic            req_user_i,
  input  logic [VA_W-1:0] base_i,
  output logic            mem_req_o,
  output logic [VA_W-1:0] mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [VA_W-1:0] mem_rdata_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [VA_W-1:0] pa_o,
  output logic [1:0]      fault_o
);
  localparam int unsigned FRM_W = VA_W - OFF_W;

  walk_st_e        st;
  logic            take_req, take_frame, finish, leaf;
  flt_e            flt;
  logic [VA_W-1:0] va_q, base_q, pa_q;
  logic            wr_q, usr_q;
  logic [FRM_W-1:0] frame_q;
  flt_e            flt_q;

  assign leaf = (st == ST_LEAF);

  pw_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i,
    .rvalid_i     (mem_rvalid_i),
    .flt_i        (flt),
    .st_o         (st),
    .take_req_o   (take_req),
    .take_frame_o (take_frame),
    .finish_o     (finish)
  );

  pw_addr_gen #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_addr (
    .base_i  (base_q),
    .va_i    (va_q),
    .frame_i (frame_q),
    .leaf_i  (leaf),
    .addr_o  (mem_addr_o)
  );

  pw_perm_chk #(.ENT_W_BITS(VA_W)) u_perm (
    .entry_i (mem_rdata_i),
    .leaf_i  (leaf),
    .write_i (wr_q),
    .user_i  (usr_q),
    .flt_o   (flt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q    <= '0;
      base_q  <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      frame_q <= '0;
      pa_q    <= '0;
      flt_q   <= FLT_NONE;
    end else begin
      if (take_req) begin
        va_q   <= req_va_i;
        base_q <= base_i;
        wr_q   <= req_write_i;
        usr_q  <= req_user_i;
      end
      if (take_frame) frame_q <= mem_rdata_i[VA_W-1 -: FRM_W];
      if (finish) begin
        flt_q <= flt;
        pa_q  <= (flt == FLT_NONE) ? {mem_rdata_i[VA_W-1 -: FRM_W], va_q[OFF_W-1:0]} : '0;
      end
    end
  end

  assign mem_req_o = (st == ST_DIR) || leaf;
  assign busy_o    = (st != ST_IDLE);
  assign done_o    = (st == ST_DONE);
  assign pa_o      = pa_q;
  assign fault_o   = flt_q;
endmodule

// File: rtl/page_walker_chk.sv
module page_walker_chk #(
  parameter int unsigned VA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            mem_req_o,
  input logic [VA_W-1:0] mem_addr_o,
  input logic            mem_rvalid_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [1:0]      fault_o
);
  // R1
  req_in_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o && !done_o);
  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));
  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R4
  fault_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> fault_o != 2'b11);
  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  // R9
  idle_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !req_valid_i |=> !busy_o);
endmodule

bind page_walker page_walker_chk #(.VA_W(VA_W)) u_chk (
  .clk_i, .rst_ni, .req_valid_i, .mem_req_o, .mem_addr_o,
  .mem_rvalid_i, .busy_o, .done_o, .fault_o
);

// File: tb/page_walker_tb_top.sv
module page_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [31:0] base = 32'h0001_0000;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        busy, done;
  logic [31:0] pa;
  logic [1:0]  fault;

  int total = 0;
  int bad = 0;
  logic [31:0] mem [logic [31:0]];

  always #2.5 clk = ~clk;

  page_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_va_i(req_va), .req_write_i(req_write),
    .req_user_i(req_user), .base_i(base),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .done_o(done), .pa_o(pa), .fault_o(fault)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference: reads, addresses, result
  task automatic ref_walk(input logic [31:0] va, input logic wr, input logic usr,
                          output int n, output logic [31:0] a0, output logic [31:0] a1,
                          output logic [1:0] f, output logic [31:0] p);
    logic [31:0] pde, pte;
    a0 = base + 32'(va[31:22]) * 4;
    pde = rd(a0);
    n = 1; a1 = '0; p = '0;
    if (!pde[0]) begin f = 2'd1; return; end
    a1 = 32'(pde[31:12]) * 4096 + 32'(va[21:12]) * 4;
    pte = rd(a1);
    n = 2;
    if (!pte[0]) f = 2'd1;
    else if ((wr && !pte[1]) || (usr && !pte[2])) f = 2'd2;
    else begin f = 2'd0; p = {pte[31:12], va[11:0]}; end
  endtask

  task automatic walk(input string req, input logic [31:0] va, input logic wr,
                      input logic usr, input int lat, input bit inject);
    int n_exp, n, cnt;
    logic [31:0] a0, a1, pexp;
    logic [1:0] fexp;
    bit addr_bad, got;
    ref_walk(va, wr, usr, n_exp, a0, a1, fexp, pexp);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_write = wr; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; cnt = 0; addr_bad = 0; got = 0;
    for (int cyc = 0; cyc < 64; cyc++) begin
      if (inject) begin
        req_valid = 1'b1; req_va = ~va; req_write = ~wr; req_user = ~usr;
      end
      if (mem_rvalid) begin
        mem_rvalid = 1'b0; cnt = 0;
      end else if (mem_req) begin
        if (mem_addr !== ((n == 0) ? a0 : a1)) addr_bad = 1;
        if (cnt >= lat) begin
          mem_rvalid = 1'b1; mem_rdata = rd(mem_addr); n++; cnt = 0;
        end else cnt++;
      end
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
    chk({req, " R4 done seen"}, 32'(got), 32'd1);
    chk({req, " R2 R3 read addresses"}, 32'(addr_bad), 32'd0);
    chk({req, " R5 read count"}, 32'(n), 32'(n_exp));
    chk({req, " R4 fault code"}, 32'(fault), 32'(fexp));
    chk({req, " R4 physical address"}, pa, pexp);
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " R9 idle after done"}, {29'd0, busy, done, mem_req}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // directory slot 1 -> table frame 0x20 (present only, no W/U: R10)
    mem[32'h0001_0004] = 32'h0002_0001;
    mem[32'h0002_0014] = 32'h1234_5007; // slot 5: P W U
    mem[32'h0002_0018] = 32'h5555_5006; // slot 6: W U, not present
    mem[32'h0002_001C] = 32'hAAAA_A005; // slot 7: P U, read-only
    mem[32'h0002_0020] = 32'h0BEE_F003; // slot 8: P W, supervisor
    // last directory slot -> frame 0x30, last table slot
    mem[32'h0001_0FFC] = 32'h0003_0007;
    mem[32'h0003_0FFC] = 32'hFEDC_B007;

    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {27'd0, busy, done, mem_req, fault}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {29'd0, busy, done, mem_req}, 32'd0);

    walk("R4 R10 basic lat0", {10'd1, 10'd5, 12'hABC}, 1'b0, 1'b1, 0, 0);
    walk("R4 basic write lat3", {10'd1, 10'd5, 12'h004}, 1'b1, 1'b1, 3, 0);
    walk("R5 null directory", {10'd2, 10'd5, 12'h010}, 1'b0, 1'b0, 2, 0);
    walk("R6 absent leaf", {10'd1, 10'd6, 12'h020}, 1'b0, 1'b0, 1, 0);
    walk("R6 absent leaf write user", {10'd1, 10'd6, 12'h020}, 1'b1, 1'b1, 0, 0);
    walk("R7 write read-only", {10'd1, 10'd7, 12'h030}, 1'b1, 1'b1, 1, 0);
    walk("R7 read read-only", {10'd1, 10'd7, 12'h030}, 1'b0, 1'b1, 2, 0);
    walk("R8 user on supervisor", {10'd1, 10'd8, 12'h040}, 1'b0, 1'b1, 0, 0);
    walk("R8 supervisor write", {10'd1, 10'd8, 12'h040}, 1'b1, 1'b0, 4, 0);
    walk("R3 R4 top indices", {10'd1023, 10'd1023, 12'hFFF}, 1'b0, 1'b1, 2, 0);
    walk("R9 busy requests ignored", {10'd1, 10'd5, 12'h123}, 1'b0, 1'b0, 2, 1);
    base = 32'h0000_0FFC; // directory moved: slot 2 now lands on 0x0000_1004
    mem[32'h0000_1004] = 32'h0003_0001;
    walk("R2 new base", {10'd2, 10'd1023, 12'h00F}, 1'b0, 1'b0, 1, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule